// File: doc/BRIEF.md
# SDRAM Single-Bank Write Sequencer

This block sits on the controller side of an SDRAM and turns a stream of write requests into a legal command sequence for one bank. Each request carries a row, a column, a length of one to four beats and an auto-precharge flag. The sequencer opens the row with ACTIVE, issues WRITE with the first data beat on the same clock, and closes the row with PRECHARGE when a request targets a different row. Every spacing rule (row-to-column delay, minimum row-open time, ACTIVE-to-ACTIVE period, write recovery and precharge time) is a cycle-count parameter. Between commands it drives NOP.

Write data comes from a separate valid/ready stream and passes straight to the data pins. The stream is popped only in cycles where the data pins carry a beat. A request that asks for fewer than four beats ends its burst early: the next WRITE to the same open row goes out on the clock right after the last wanted beat. A four-beat request followed by another four-beat request therefore gives eight unbroken beats on the data pins.

Top module: `sdram_wr_seq`

## Requirements
- R1: After reset, with no request pending, the command output is NOP (code 0), the data output enable is low and neither ready output is high.
- R2: Commands are coded NOP=0, ACTIVE=1, WRITE=2, PRECHARGE=3. ACTIVE puts the row on the address output. WRITE puts the column on the low address bits and the auto-precharge flag on address bit 10. An explicit PRECHARGE has address bit 10 low, so it closes only the addressed bank.
- R3: A WRITE is issued only to an open row, and no sooner than TRCD cycles after its ACTIVE. When the timers are idle it comes exactly TRCD cycles after the ACTIVE.
- R4: In the WRITE cycle the first data beat is on the data output, the output enable is high and the write-data ready is high.
- R5: A request of length L drives exactly L beats on consecutive cycles, starting with the WRITE cycle. The beats land at columns that step upward and wrap within the aligned group of four (column bits 1:0 count up modulo 4). Columns that are not driven keep their old contents.
- R6: When the next request targets the same open row, its WRITE is issued exactly L cycles after the previous WRITE, where L is the earlier request's length. Four-beat requests therefore chain with no idle cycle, and shorter ones cut the burst short.
- R7: PRECHARGE is issued no sooner than TRAS cycles after ACTIVE, and no sooner than TWR cycles after the last data beat.
- R8: ACTIVE is issued no sooner than TRP cycles after PRECHARGE, and no sooner than TRC cycles after the previous ACTIVE.
- R9: After a WRITE with auto-precharge, no explicit PRECHARGE is issued. The next ACTIVE waits at least TWR+TRP cycles after that burst's last beat.
- R10: A request to a row other than the open one causes exactly one PRECHARGE and then an ACTIVE carrying the new row before its WRITE.
- R11: A WRITE waits for the write-data valid input. While data is not available, no WRITE is issued and neither ready output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Request accepted this cycle (its WRITE is issued) |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Starting column |
| req_len | input | 3 | Beats wanted, 1 to 4 |
| req_ap | input | 1 | Close the row automatically after this burst |
| wd_valid | input | 1 | Write data present |
| wd_ready | output | 1 | Write data consumed this cycle |
| wd_data | input | DQ_W | Write data |
| cmd_o | output | 2 | Command code (NOP, ACTIVE, WRITE, PRECHARGE) |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ROW_W | Row, or column plus flag in bit 10 |
| dq_o | output | DQ_W | Data to memory |
| dq_oe | output | 1 | Data output enable |

## Verification
The hardest case to reach is a WRITE that cuts a burst short and then lands on a column group that wraps. A request has to be ready in the exact cycle after the last wanted beat, and the start column has to sit inside the group. The bench drives each next request right after the clock edge on which the previous one is accepted, so it is pending in that cycle. It follows a two-beat request with a one-beat request and then a three-beat request starting at column 6. The behavioural memory then shows columns 2 and 3 left unwritten and column 4 written by the wrapped third beat. Auto-precharge spacing is reached by a row switch followed by two requests to the new row, the first with auto-precharge set.

// File: rtl/sdram_wr_pkg.sv
package sdram_wr_pkg;
    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_ACT = 2'd1,
        CMD_WR  = 2'd2,
        CMD_PRE = 2'd3
    } cmd_e;

    typedef enum logic {
        ROW_SHUT = 1'b0,
        ROW_OPEN = 1'b1
    } row_e;
endpackage

// File: rtl/sdram_wr_timer.sv
// Down-counter that blocks a command until the loaded spacing has elapsed.
module sdram_wr_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         done_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sdram_wr_beats.sv
// Tracks the data beats that remain after the WRITE cycle of a burst.
module sdram_wr_beats (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [2:0] len_i,
    output logic       busy_o,
    output logic       last_o
);
    logic [1:0] left_d, left_q;

    always_comb begin
        left_d = left_q;
        if (start_i)
            left_d = 2'(len_i - 3'd1);
        else if (left_q != 2'd0)
            left_d = left_q - 2'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) left_q <= 2'd0;
        else        left_q <= left_d;
    end

    assign busy_o = (left_q != 2'd0);
    assign last_o = start_i ? (len_i <= 3'd1) : (left_q == 2'd1);
endmodule

// File: rtl/sdram_wr_seq.sv
module sdram_wr_seq
    import sdram_wr_pkg::*;
#(
    parameter int ROW_W = 13,
    parameter int COL_W = 9,
    parameter int BA_W  = 2,
    parameter int BANK  = 0,
    parameter int DQ_W  = 16,
    parameter int TRCD  = 3,
    parameter int TRAS  = 6,
    parameter int TRC   = 9,
    parameter int TWR   = 2,
    parameter int TRP   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  logic [2:0]       req_len,
    input  logic             req_ap,
    input  logic             wd_valid,
    output logic             wd_ready,
    input  logic [DQ_W-1:0]  wd_data,
    output logic [1:0]       cmd_o,
    output logic [BA_W-1:0]  ba_o,
    output logic [ROW_W-1:0] addr_o,
    output logic [DQ_W-1:0]  dq_o,
    output logic             dq_oe
);
    localparam int FLAG_BIT = 10;
    localparam int TMR_W    = $clog2(TRAS + TRC + TWR + TRP + 1);

    typedef struct packed {
        row_e             st;
        logic [ROW_W-1:0] row;
        logic             ap;
    } seq_s;

    seq_s seq_d, seq_q;
    cmd_e cmd;
    logic ld_act, ld_pre, wr_start, ap_now;
    logic beat_busy, beat_last;
    logic rcd_done, ras_done, rc_done, wr_done, rp_done;
    logic [ROW_W-1:0] wr_addr;

    always_comb begin
        seq_d     = seq_q;
        cmd       = CMD_NOP;
        addr_o    = '0;
        dq_oe     = 1'b0;
        req_ready = 1'b0;
        wr_start  = 1'b0;
        ld_act    = 1'b0;
        ld_pre    = 1'b0;
        wr_addr   = '0;
        wr_addr[COL_W-1:0] = req_col;
        wr_addr[FLAG_BIT]  = req_ap;
        if (beat_busy) begin
            dq_oe = 1'b1;
        end else if (req_valid) begin
            if (seq_q.st == ROW_SHUT) begin
                if (rp_done && rc_done) begin
                    cmd       = CMD_ACT;
                    addr_o    = req_row;
                    ld_act    = 1'b1;
                    seq_d.st  = ROW_OPEN;
                    seq_d.row = req_row;
                end
            end else if (req_row == seq_q.row) begin
                if (rcd_done && wd_valid) begin
                    cmd       = CMD_WR;
                    addr_o    = wr_addr;
                    dq_oe     = 1'b1;
                    req_ready = 1'b1;
                    wr_start  = 1'b1;
                    seq_d.ap  = req_ap;
                end
            end else if (ras_done && wr_done) begin
                cmd      = CMD_PRE;
                ld_pre   = 1'b1;
                seq_d.st = ROW_SHUT;
            end
        end
        ap_now = wr_start ? req_ap : seq_q.ap;
        if (beat_last && dq_oe && ap_now)
            seq_d.st = ROW_SHUT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: ROW_SHUT, row: '0, ap: 1'b0};
        else        seq_q <= seq_d;
    end

    assign cmd_o    = cmd;
    assign ba_o     = BA_W'(BANK);
    assign dq_o     = wd_data;
    assign wd_ready = dq_oe;

    sdram_wr_beats u_beats (
        .clk(clk), .rst_n(rst_n), .start_i(wr_start), .len_i(req_len),
        .busy_o(beat_busy), .last_o(beat_last)
    );

    logic end_plain, end_ap;
    assign end_plain = beat_last && dq_oe && !ap_now;
    assign end_ap    = beat_last && dq_oe && ap_now;

    sdram_wr_timer #(.W(TMR_W)) u_rcd (
        .clk(clk), .rst_n(rst_n), .load_i(ld_act),
        .val_i(TMR_W'(TRCD - 1)), .done_o(rcd_done));
    sdram_wr_timer #(.W(TMR_W)) u_ras (
        .clk(clk), .rst_n(rst_n), .load_i(ld_act),
        .val_i(TMR_W'(TRAS - 1)), .done_o(ras_done));
    sdram_wr_timer #(.W(TMR_W)) u_rc (
        .clk(clk), .rst_n(rst_n), .load_i(ld_act),
        .val_i(TMR_W'(TRC - 1)), .done_o(rc_done));
    sdram_wr_timer #(.W(TMR_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .load_i(end_plain),
        .val_i(TMR_W'(TWR - 1)), .done_o(wr_done));
    sdram_wr_timer #(.W(TMR_W)) u_rp (
        .clk(clk), .rst_n(rst_n), .load_i(ld_pre || end_ap),
        .val_i(ld_pre ? TMR_W'(TRP - 1) : TMR_W'(TWR + TRP - 1)),
        .done_o(rp_done));

    // Assertion support: cycles since each event, saturating, independent of the timers.
    logic [7:0] s_act_q, s_pre_q, s_oe_q;
    logic       apw_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_act_q <= 8'hFF;
            s_pre_q <= 8'hFF;
            s_oe_q  <= 8'hFF;
            apw_q   <= 1'b0;
        end else begin
            s_act_q <= (cmd_o == CMD_ACT) ? 8'd1 : (s_act_q == 8'hFF ? s_act_q : s_act_q + 8'd1);
            s_pre_q <= (cmd_o == CMD_PRE) ? 8'd1 : (s_pre_q == 8'hFF ? s_pre_q : s_pre_q + 8'd1);
            s_oe_q  <= dq_oe ? 8'd1 : (s_oe_q == 8'hFF ? s_oe_q : s_oe_q + 8'd1);
            if (cmd_o == CMD_WR) apw_q <= addr_o[FLAG_BIT];
        end
    end

    p_rcd_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_WR) |-> (32'(s_act_q) >= TRCD));
    p_data_with_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_WR) |-> (dq_oe && wd_ready));
    p_beats_contiguous_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && cmd_o != CMD_WR) |-> $past(dq_oe));
    p_pre_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_PRE) |-> (32'(s_act_q) >= TRAS && 32'(s_oe_q) >= TWR));
    p_act_spacing_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_ACT) |-> (32'(s_pre_q) >= TRP && 32'(s_act_q) >= TRC));
    p_autopre_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_ACT && apw_q) |-> (32'(s_oe_q) >= TWR + TRP));
    p_wait_for_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!wd_valid && !beat_busy) |-> (cmd_o != CMD_WR && !req_ready));
endmodule

// File: tb/sdram_wr_seq_tb.sv
`timescale 1ns/1ps
module sdram_wr_seq_tb_top;
    localparam int TRCD = 3, TRAS = 6, TRC = 9, TWR = 2, TRP = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_ap = 1'b0, wd_valid = 1'b1;
    logic        req_ready, wd_ready, dq_oe;
    logic [12:0] req_row = '0, addr_o;
    logic [8:0]  req_col = '0;
    logic [2:0]  req_len = 3'd1;
    logic [15:0] wd_data, dq_o;
    logic [1:0]  cmd_o, ba_o;

    always #2.5 clk = ~clk;

    sdram_wr_seq #(.TRCD(TRCD), .TRAS(TRAS), .TRC(TRC), .TWR(TWR), .TRP(TRP)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_row(req_row), .req_col(req_col), .req_len(req_len), .req_ap(req_ap),
        .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
        .cmd_o(cmd_o), .ba_o(ba_o), .addr_o(addr_o), .dq_o(dq_o), .dq_oe(dq_oe));

    int checks = 0, errors = 0;
    int widx = 0;
    assign wd_data = 16'hA000 + widx[15:0];
    always @(posedge clk) if (rst_n && wd_valid && wd_ready) widx <= widx + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural memory and command-legality monitor.
    logic [15:0] mem [0:3][0:15];
    int cyc = 0, act_c = -1000, pre_c = -1000, oe_c = -1000;
    int n_act = 0, n_pre = 0, n_oe = 0, orow = 0, wcol = 0, wk = 0;
    bit open_r = 0, apw = 0;
    int wr_log[$];
    bit ap_log[$];

    always @(negedge clk) if (rst_n) begin
        cyc++;
        case (cmd_o)
            2'd1: begin
                chk(cyc - pre_c >= TRP, "R8", "ACT after PRE gap", cyc - pre_c, TRP);
                chk(cyc - act_c >= TRC, "R8", "ACT to ACT gap", cyc - act_c, TRC);
                if (apw) chk(cyc - oe_c >= TWR + TRP, "R9", "ACT after auto-precharge",
                             cyc - oe_c, TWR + TRP);
                open_r = 1; orow = int'(addr_o); act_c = cyc; n_act++; apw = 0;
            end
            2'd2: begin
                chk(open_r, "R3", "WRITE to open row", int'(open_r), 1);
                chk(cyc - act_c >= TRCD, "R3", "ACT to WRITE gap", cyc - act_c, TRCD);
                chk(dq_oe && wd_ready, "R4", "data on WRITE cycle", int'(dq_oe && wd_ready), 1);
                wcol = int'(addr_o[8:0]); wk = 0; apw = addr_o[10];
                wr_log.push_back(cyc); ap_log.push_back(addr_o[10]);
            end
            2'd3: begin
                chk(addr_o[10] == 1'b0, "R2", "PRE bit 10", int'(addr_o[10]), 0);
                chk(cyc - act_c >= TRAS, "R7", "ACT to PRE gap", cyc - act_c, TRAS);
                chk(cyc - oe_c >= TWR, "R7", "last beat to PRE gap", cyc - oe_c, TWR);
                open_r = 0; pre_c = cyc; n_pre++;
            end
            default: ;
        endcase
        if (dq_oe) begin
            mem[orow][(wcol & ~3) | ((wcol + wk) & 3)] = dq_o;
            wk++; oe_c = cyc; n_oe++;
        end
    end

    task automatic wait_accept();
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        @(posedge clk); #1;
    endtask

    task automatic send(input int row, input int col, input int len, input bit ap);
        req_valid = 1'b1; req_row = 13'(row); req_col = 9'(col);
        req_len = 3'(len); req_ap = ap;
        wait_accept();
    endtask

    task automatic idle(input int n);
        req_valid = 1'b0;
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(cmd_o == 2'd0, "R1", "cmd after reset", int'(cmd_o), 0);
        chk(!dq_oe && !wd_ready && !req_ready, "R1", "enables after reset",
            int'({dq_oe, wd_ready, req_ready}), 0);
    endtask

    task automatic t_single();
        int base = widx;
        send(1, 4, 4, 1'b0);
        idle(12);
        chk(wr_log[$] - act_c == TRCD, "R3", "idle ACT to WRITE exact", wr_log[$] - act_c, TRCD);
        chk(ap_log[$] == 1'b0, "R2", "WRITE bit 10 without auto-precharge", int'(ap_log[$]), 0);
        for (int k = 0; k < 4; k++)
            chk(mem[1][4 + k] == 16'(16'hA000 + base + k), "R5", "single burst data",
                int'(mem[1][4 + k]), 'hA000 + base + k);
    endtask

    task automatic t_concat();
        int base = widx;
        int n0 = n_oe;
        send(1, 8, 4, 1'b0);
        send(1, 12, 4, 1'b0);
        idle(12);
        chk(wr_log[$] - wr_log[$-1] == 4, "R6", "chained WRITE spacing",
            wr_log[$] - wr_log[$-1], 4);
        chk(n_oe - n0 == 8, "R6", "chained beat count", n_oe - n0, 8);
        for (int k = 0; k < 8; k++)
            chk(mem[1][8 + k] == 16'(16'hA000 + base + k), "R6", "chained data",
                int'(mem[1][8 + k]), 'hA000 + base + k);
    endtask

    task automatic t_trunc();
        int base = widx;
        send(1, 0, 2, 1'b0);
        send(1, 5, 1, 1'b0);
        send(1, 6, 3, 1'b0);
        idle(12);
        chk(wr_log[$-1] - wr_log[$-2] == 2, "R6", "truncate after two beats",
            wr_log[$-1] - wr_log[$-2], 2);
        chk(wr_log[$] - wr_log[$-1] == 1, "R6", "truncate after one beat",
            wr_log[$] - wr_log[$-1], 1);
        chk(mem[1][0] == 16'(16'hA000 + base) && mem[1][1] == 16'(16'hA001 + base), "R5",
            "truncated beats", int'(mem[1][1]), 'hA001 + base);
        chk(mem[1][2] == 16'h0 && mem[1][3] == 16'h0, "R5", "undriven columns untouched",
            int'(mem[1][2] | mem[1][3]), 0);
        chk(mem[1][5] == 16'(16'hA002 + base), "R5", "single beat", int'(mem[1][5]), 'hA002 + base);
        chk(mem[1][6] == 16'(16'hA003 + base) && mem[1][7] == 16'(16'hA004 + base), "R5",
            "wrap burst first beats", int'(mem[1][7]), 'hA004 + base);
        chk(mem[1][4] == 16'(16'hA005 + base), "R5", "wrap burst third beat at column 4",
            int'(mem[1][4]), 'hA005 + base);
    endtask

    task automatic t_row_miss();
        int base = widx;
        int np = n_pre;
        send(2, 0, 4, 1'b0);
        idle(12);
        chk(n_pre == np + 1, "R10", "one PRECHARGE on row change", n_pre - np, 1);
        chk(orow == 2, "R10", "ACT row", orow, 2);
        chk(mem[2][3] == 16'(16'hA003 + base), "R10", "data in new row",
            int'(mem[2][3]), 'hA003 + base);
    endtask

    task automatic t_autopre();
        int np = n_pre;
        int na = n_act;
        int base = widx;
        send(3, 0, 1, 1'b1);
        send(3, 1, 1, 1'b0);
        idle(14);
        chk(n_pre == np + 1, "R9", "no explicit PRECHARGE after auto-precharge", n_pre - np, 1);
        chk(n_act == na + 2, "R9", "row reopened after auto-precharge", n_act - na, 2);
        chk(ap_log[$-1] == 1'b1, "R2", "WRITE bit 10 with auto-precharge", int'(ap_log[$-1]), 1);
        chk(mem[3][1] == 16'(16'hA001 + base), "R9", "data after reopen",
            int'(mem[3][1]), 'hA001 + base);
    endtask

    task automatic t_stall();
        int nw = wr_log.size();
        wd_valid = 1'b0;
        req_valid = 1'b1; req_row = 13'd3; req_col = 9'd8; req_len = 3'd2; req_ap = 1'b0;
        repeat (6) begin
            @(negedge clk);
            chk(cmd_o != 2'd2 && !wd_ready && !req_ready, "R11", "no WRITE without data",
                int'(cmd_o), 0);
        end
        @(posedge clk); #1;
        wd_valid = 1'b1;
        wait_accept();
        idle(8);
        chk(wr_log.size() == nw + 1, "R11", "WRITE once data arrives", wr_log.size() - nw, 1);
    endtask

    initial begin
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 16; c++)
                mem[r][c] = 16'h0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        @(posedge clk); #1;
        t_single();
        t_concat();
        t_trunc();
        t_row_miss();
        t_autopre();
        t_stall();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule